// File: doc/BRIEF.md
# LIN Break Field Receiver

This block is the receive front end of a LIN slave node. It watches one oversampled serial line and measures time in bit periods. The bit period is set by a clocks-per-bit input. The block starts asleep. A falling edge on the line wakes it and moves it into a dedicated break-wait mode. In that mode it times the next dominant (low) run. Once the line returns high, it rules that the run was either a valid break or a break error. No byte assembly, error flags or data transfer take place while it waits for or times a break.

A valid break hands off to an edge-capture timer. The timer measures the sync byte that follows. It timestamps the falling edges of that byte against a free-running counter. It then offers the span from the first to the fifth falling edge, which is eight bit times, on a valid/ready result port. Firmware can divide that span by eight to learn the master's true bit time. The result stays on the port until it is accepted. While it waits, the block takes no new break.

A halt input sends the block back to sleep from any state. It also clears the capture timer. After a halt, a fresh wakeup edge is needed before another break can be timed.

Top module: `lin_brk_rx`

## Requirements
- R1: After reset the block is asleep: `asleep`=1, `brk_mode`=0, `meas_valid`=0, `break_ok`=0, `break_err`=0.
- R2: While asleep, a falling edge on `rx_i` clears `asleep` and sets `brk_mode` within 4 clock cycles.
- R3: In break mode, a low run of at least 11 × `bit_clks` clocks gives exactly one single-cycle `break_ok` pulse once the line returns high, and no `break_err`. The bench tests a run of exactly 11 bit times and the nominal 13 bit times.
- R4: In break mode, a low run shorter than 11 × `bit_clks` clocks (10 bit times plus 7 clocks is tested) gives exactly one single-cycle `break_err` pulse and no `break_ok`, and leaves `brk_mode`=1.
- R5: The low-run bit count saturates. A 40-bit-time low run is still a valid break.
- R6: After `break_ok`, the block timestamps the falling edges of the sync byte 0x55, sent LSB first with a low start bit. `meas_span` then shows the clock count between the first and fifth falling edges, which is 8 times the actual bit period, and `meas_valid` is asserted.
- R7: Back-pressure: while `meas_valid`=1 and `meas_ready`=0, `meas_valid` stays 1 and `meas_span` is stable. The cycle after a handshake, the block is back in break mode (`meas_valid`=0, `brk_mode`=1).
- R8: `halt` forces the sleep state on the next clock from any state and drops `meas_valid`. Afterwards the first falling edge only wakes the block and is never timed as a break.
- R9: The bit period follows `bit_clks` (values of at least 2 are supported). The same low run in clocks is judged against the current value.
- R10: A break error and break-mode reception never produce a result: `meas_valid` stays 0 whenever `brk_mode`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| halt | input | 1 | Return to sleep and clear the capture timer |
| rx_i | input | 1 | Asynchronous serial receive line |
| bit_clks | input | 16 | Clocks per bit time (at least 2) |
| asleep | output | 1 | Block is in the sleep state |
| brk_mode | output | 1 | Block is waiting for or timing a break |
| break_ok | output | 1 | One-cycle pulse: valid break completed |
| break_err | output | 1 | One-cycle pulse: low run too short |
| meas_valid | output | 1 | Sync measurement available |
| meas_ready | input | 1 | Consumer accepts the measurement |
| meas_span | output | 16 | Clocks from first to fifth sync falling edge |

## Verification
A fault in the low-run counter shows up at the threshold. A bit count that is off by one, or that wraps, flips the outcome at exactly 11 bit times, at 10 bit times plus a fraction, or on a 40-bit stuck-low run. The wrong `break_ok` or `break_err` pulse then appears a few cycles after the line rises. A fault in the state sequencing shows within a few clocks of a wakeup, a halt or a handshake, through `asleep` and `brk_mode`. A fault in the capture edge index or its timestamp shows as a `meas_span` that is not 8 times the driven bit period, once the fifth sync falling edge has passed.

// File: rtl/lin_brk_pkg.sv
package lin_brk_pkg;
  typedef enum logic [2:0] {
    ST_SLEEP = 3'd0,
    ST_ARMED = 3'd1,
    ST_LOW   = 3'd2,
    ST_SYNC  = 3'd3,
    ST_HOLD  = 3'd4
  } lin_st_t;
endpackage

// File: rtl/lin_brk_sync.sv
module lin_brk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b1;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/lin_brk_lowrun.sv
module lin_brk_lowrun #(
  parameter int DIVW = 16,
  parameter int BITW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            run,
  input  logic [DIVW-1:0] bit_clks,
  output logic [BITW-1:0] bits
);
  localparam logic [BITW-1:0] BITS_MAX = {BITW{1'b1}};

  logic [DIVW-1:0] cyc;
  logic            bit_end;

  assign bit_end = (cyc >= bit_clks - 16'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc  <= '0;
      bits <= '0;
    end else if (start) begin
      // the edge cycle itself is the first low clock
      cyc  <= {{(DIVW-1){1'b0}}, 1'b1};
      bits <= '0;
    end else if (run) begin
      if (bit_end) begin
        cyc <= '0;
        if (bits != BITS_MAX) bits <= bits + 1'b1;
      end else begin
        cyc <= cyc + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lin_brk_capture.sv
module lin_brk_capture #(
  parameter int CNTW  = 16,
  parameter int EDGES = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            active,
  input  logic            fall,
  output logic            done,
  output logic [CNTW-1:0] span
);
  localparam int IDXW = $clog2(EDGES + 1);
  localparam logic [IDXW-1:0] LAST = IDXW'(EDGES - 1);

  logic [CNTW-1:0] tick;
  logic [CNTW-1:0] t_first;
  logic [IDXW-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   tick <= '0;
    else if (clr) tick <= '0;
    else          tick <= tick + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx     <= '0;
      t_first <= '0;
      span    <= '0;
      done    <= 1'b0;
    end else if (clr) begin
      idx     <= '0;
      t_first <= '0;
      span    <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        idx <= '0;
      end else if (fall) begin
        if (idx == '0) t_first <= tick;
        if (idx == LAST) begin
          span <= tick - t_first;
          done <= 1'b1;
        end
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lin_brk_rx.sv
module lin_brk_rx
  import lin_brk_pkg::*;
#(
  parameter int DIVW     = 16,
  parameter int BITW     = 5,
  parameter int MIN_BITS = 11,
  parameter int SYNC_FF  = 2,
  parameter int EDGES    = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            halt,
  input  logic            rx_i,
  input  logic [DIVW-1:0] bit_clks,
  output logic            asleep,
  output logic            brk_mode,
  output logic            break_ok,
  output logic            break_err,
  output logic            meas_valid,
  input  logic            meas_ready,
  output logic [DIVW-1:0] meas_span
);
  localparam logic [BITW-1:0] MIN_RUN = BITW'(MIN_BITS);

  lin_st_t         st, st_nx;
  logic            rx_s, rx_d, fall, rise;
  logic            lr_start, lr_run;
  logic [BITW-1:0] lr_bits;
  logic            cap_done;
  logic            ok_nx, err_nx;

  lin_brk_sync #(.STAGES(SYNC_FF)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rx_i), .q(rx_s)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rx_d <= 1'b1;
    else        rx_d <= rx_s;

  assign fall = rx_d & ~rx_s;
  assign rise = ~rx_d & rx_s;

  assign lr_start = (st == ST_ARMED) && fall;
  assign lr_run   = (st == ST_LOW) && !rx_s;

  lin_brk_lowrun #(.DIVW(DIVW), .BITW(BITW)) u_lowrun (
    .clk(clk), .rst_n(rst_n), .start(lr_start), .run(lr_run),
    .bit_clks(bit_clks), .bits(lr_bits)
  );

  lin_brk_capture #(.CNTW(DIVW), .EDGES(EDGES)) u_cap (
    .clk(clk), .rst_n(rst_n), .clr(halt), .active(st == ST_SYNC),
    .fall(fall), .done(cap_done), .span(meas_span)
  );

  always_comb begin
    st_nx  = st;
    ok_nx  = 1'b0;
    err_nx = 1'b0;
    unique case (st)
      ST_SLEEP: if (fall) st_nx = ST_ARMED;
      ST_ARMED: if (fall) st_nx = ST_LOW;
      ST_LOW: if (rise) begin
        if (lr_bits >= MIN_RUN) begin
          st_nx = ST_SYNC;
          ok_nx = 1'b1;
        end else begin
          st_nx  = ST_ARMED;
          err_nx = 1'b1;
        end
      end
      ST_SYNC: if (cap_done) st_nx = ST_HOLD;
      ST_HOLD: if (meas_ready) st_nx = ST_ARMED;
      default: st_nx = ST_SLEEP;
    endcase
    if (halt) begin
      st_nx  = ST_SLEEP;
      ok_nx  = 1'b0;
      err_nx = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_SLEEP;
      break_ok  <= 1'b0;
      break_err <= 1'b0;
    end else begin
      st        <= st_nx;
      break_ok  <= ok_nx;
      break_err <= err_nx;
    end
  end

  assign asleep     = (st == ST_SLEEP);
  assign brk_mode   = (st == ST_ARMED) || (st == ST_LOW);
  assign meas_valid = (st == ST_HOLD);
endmodule

// File: rtl/lin_brk_rx_chk.sv
module lin_brk_rx_chk #(
  parameter int DIVW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            halt,
  input logic            asleep,
  input logic            brk_mode,
  input logic            break_ok,
  input logic            break_err,
  input logic            meas_valid,
  input logic            meas_ready,
  input logic [DIVW-1:0] meas_span
);
  a_r3_ok_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    break_ok |=> !break_ok);

  a_r4_err_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    break_err |=> !break_err);

  a_r4_ok_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(break_ok && break_err));

  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_valid && !meas_ready && !halt) |=> (meas_valid && $stable(meas_span)));

  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_valid && meas_ready && !halt) |=> (brk_mode && !meas_valid));

  a_r8_halt_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (asleep && !meas_valid && !break_ok && !break_err));

  a_r10_no_result_in_break: assert property (@(posedge clk) disable iff (!rst_n)
    brk_mode |-> !meas_valid);

  a_r2_states_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({asleep, brk_mode, meas_valid}));
endmodule

bind lin_brk_rx lin_brk_rx_chk #(.DIVW(DIVW)) u_chk (
  .clk(clk), .rst_n(rst_n), .halt(halt), .asleep(asleep),
  .brk_mode(brk_mode), .break_ok(break_ok), .break_err(break_err),
  .meas_valid(meas_valid), .meas_ready(meas_ready), .meas_span(meas_span)
);

// File: tb/lin_brk_rx_tb.sv
`timescale 1ns/1ps
module lin_brk_rx_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        halt = 1'b0;
  logic        rx_i = 1'b1;
  logic [15:0] bit_clks = 16'd8;
  logic        meas_ready = 1'b0;
  logic        asleep, brk_mode, break_ok, break_err, meas_valid;
  logic [15:0] meas_span;

  int checks = 0;
  int errors = 0;
  int n_ok = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  lin_brk_rx u_dut (
    .clk(clk), .rst_n(rst_n), .halt(halt), .rx_i(rx_i), .bit_clks(bit_clks),
    .asleep(asleep), .brk_mode(brk_mode), .break_ok(break_ok),
    .break_err(break_err), .meas_valid(meas_valid), .meas_ready(meas_ready),
    .meas_span(meas_span)
  );

  always @(negedge clk) begin
    if (break_ok)  n_ok++;
    if (break_err) n_err++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic low_run(input int len);
    rx_i = 1'b0;
    cyc(len);
    rx_i = 1'b1;
    cyc(10);
  endtask

  task automatic send_sync(input int q);
    logic [9:0] frame = {1'b1, 8'h55, 1'b0};
    for (int i = 0; i < 10; i++) begin
      rx_i = frame[i];
      cyc(q);
    end
    rx_i = 1'b1;
  endtask

  task automatic wait_valid(input int limit);
    for (int i = 0; i < limit && !meas_valid; i++) cyc(1);
  endtask

  task automatic t_reset;
    chk(asleep == 1'b1, "R1", "asleep", asleep, 1);
    chk(brk_mode == 1'b0, "R1", "brk_mode", brk_mode, 0);
    chk(meas_valid == 1'b0, "R1", "meas_valid", meas_valid, 0);
    chk(!break_ok && !break_err, "R1", "pulses", break_ok + break_err, 0);
  endtask

  task automatic t_wake;
    rx_i = 1'b0;
    cyc(2);
    rx_i = 1'b1;
    cyc(2);
    chk(asleep == 1'b0, "R2", "asleep after wake", asleep, 0);
    chk(brk_mode == 1'b1, "R2", "brk_mode after wake", brk_mode, 1);
    cyc(6);
  endtask

  task automatic t_short;
    int ok0 = n_ok, er0 = n_err;
    low_run(5 * 8);
    chk(n_err - er0 == 1, "R4", "err pulses 5 bits", n_err - er0, 1);
    chk(n_ok - ok0 == 0, "R4", "ok pulses 5 bits", n_ok - ok0, 0);
    chk(brk_mode == 1'b1, "R4", "still break mode", brk_mode, 1);
    chk(meas_valid == 1'b0, "R10", "no result on error", meas_valid, 0);
  endtask

  task automatic t_edge_short;
    int ok0 = n_ok, er0 = n_err;
    low_run(11 * 8 - 1);
    chk(n_err - er0 == 1, "R4", "err pulses 11b-1", n_err - er0, 1);
    chk(n_ok - ok0 == 0, "R4", "ok pulses 11b-1", n_ok - ok0, 0);
  endtask

  task automatic handshake(input string req);
    int s0 = meas_span;
    meas_ready = 1'b0;
    cyc(20);
    chk(meas_valid == 1'b1, "R7", "valid held under back-pressure", meas_valid, 1);
    chk(meas_span == s0, "R7", "span stable under back-pressure", meas_span, s0);
    meas_ready = 1'b1;
    cyc(1);
    meas_ready = 1'b0;
    chk(meas_valid == 1'b0 && brk_mode == 1'b1, req, "back to break mode",
        {meas_valid, brk_mode}, 1);
  endtask

  task automatic t_exact11;
    int ok0 = n_ok, er0 = n_err;
    low_run(11 * 8);
    chk(n_ok - ok0 == 1, "R3", "ok pulses 11 bits", n_ok - ok0, 1);
    chk(n_err - er0 == 0, "R3", "err pulses 11 bits", n_err - er0, 0);
    send_sync(8);
    wait_valid(200);
    chk(meas_valid == 1'b1, "R6", "valid after sync", meas_valid, 1);
    chk(meas_span == 64, "R6", "span at 8 clk/bit", meas_span, 64);
    handshake("R7");
  endtask

  task automatic t_nominal;
    int ok0 = n_ok;
    low_run(13 * 8);
    chk(n_ok - ok0 == 1, "R3", "ok pulses 13 bits", n_ok - ok0, 1);
    send_sync(9);
    wait_valid(200);
    chk(meas_span == 72, "R6", "span with slower master", meas_span, 72);
    meas_ready = 1'b1;
    cyc(1);
    meas_ready = 1'b0;
  endtask

  task automatic t_period;
    int ok0 = n_ok, er0 = n_err;
    bit_clks = 16'd4;
    cyc(2);
    low_run(11 * 4 - 2);
    chk(n_err - er0 == 1, "R9", "err at 4 clk/bit", n_err - er0, 1);
    low_run(40 * 4);
    chk(n_ok - ok0 == 1, "R5", "40-bit run valid", n_ok - ok0, 1);
    chk(n_err - er0 == 1, "R5", "no err on long run", n_err - er0, 1);
    send_sync(4);
    wait_valid(200);
    chk(meas_span == 32, "R9", "span at 4 clk/bit", meas_span, 32);
    meas_ready = 1'b1;
    cyc(1);
    meas_ready = 1'b0;
    low_run(44);
    chk(n_ok - ok0 == 2, "R9", "44 clocks valid at 4 clk/bit", n_ok - ok0, 2);
  endtask

  task automatic t_halt;
    int ok0;
    halt = 1'b1;
    cyc(1);
    halt = 1'b0;
    chk(asleep == 1'b1, "R8", "asleep after halt", asleep, 1);
    chk(meas_valid == 1'b0, "R8", "no result after halt", meas_valid, 0);
    ok0 = n_ok;
    low_run(13 * 4);
    chk(n_ok - ok0 == 0, "R8", "wake edge not timed", n_ok - ok0, 0);
    chk(brk_mode == 1'b1, "R8", "woken into break mode", brk_mode, 1);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_wake();
    t_short();
    t_edge_short();
    t_exact11();
    t_nominal();
    t_period();
    t_halt();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule